// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the byte-wide register front end of a three-channel interval timer. A host reaches it through a 2-bit address: the three lowest addresses are the data ports of channels 0 to 2, and the top address is a shared control port. Control bytes written there set a channel's byte access scheme, its operating mode and its decimal flag. They can also freeze a channel's count, or freeze count and status for several channels at once. Data-port writes assemble 16-bit reload values one byte at a time. Data-port reads return either a frozen value or the live count, in the byte order the access scheme selects.

The counting itself happens in three separate channel cores. This block hands each core a one-cycle load strobe with a 16-bit reload value, plus its mode and decimal flag. It samples each core's live count and output level. Only one bus transfer is made per cycle. Read data is combinational from the address, and the read takes effect at the clock edge that ends a cycle with `bus_rd` high.

Top module: `tmr_bus_top`

## Requirements
- R1: After reset every channel uses low-then-high byte access with mode 0 and decimal flag 0, holds no frozen count or status, and has both byte pointers at the low byte. No load strobe is active.
- R2: A control byte whose bits 7:6 are 0, 1 or 2 and whose bits 5:4 are nonzero reconfigures that channel. Bits 5:4 give the access scheme (1 low byte only, 2 high byte only, 3 low then high), bits 3:1 the mode and bit 0 the decimal flag. The mode and flag appear on `ch_mode`/`ch_bcd` after the clock edge, and both byte pointers return to the low byte.
- R3: In low-only access a data write loads {8'h00, byte}. In high-only access it loads {byte, 8'h00}. The channel's `ch_load` bit is high for exactly the one cycle after the write edge.
- R4: In low-then-high access the first data write only holds its byte and gives no load. The second loads {second, first}, and the next write is again taken as a low byte.
- R5: A control byte with bits 5:4 equal to 0 freezes the addressed channel's live count. A further freeze request, from that command or from a read-back, is ignored while an earlier frozen count is still unread.
- R6: A frozen count is read out in the channel's byte scheme (low only, high only, or low then high). It is released after its final byte, and later reads return live data.
- R7: Without a frozen value, low-only reads return the live low byte and high-only reads the live high byte. Low-then-high reads alternate low, high, low, and so on.
- R8: A control byte with bits 7:6 both set is a read-back. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 low freezes the count (subject to R5), and bit 4 low freezes status, which is ignored if status is already frozen and unread.
- R9: The status byte is {output level, 0, access scheme[1:0], mode[2:0], decimal flag}.
- R10: A frozen status is returned by the next data read before any frozen count, and is released after that one read while the frozen count stays pending.
- R11: A read of the control-port address returns 8'h00 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | 0..2 data port of a channel, 3 control port |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe; state advances at the edge ending the cycle |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte for the addressed port |
| ch_load | output | 3 | Per-channel reload strobe |
| ch_load_val | output | 48 | Reload values, channel i in bits 16i+15:16i |
| ch_mode | output | 9 | Operating modes, channel i in bits 3i+2:3i |
| ch_bcd | output | 3 | Decimal flags |
| ch_count | input | 48 | Live counts from the cores, channel i in bits 16i+15:16i |
| ch_out | input | 3 | Output levels from the cores |

## Verification
A byte pointer that is out of step shows up on the next data read: the two halves of the live count swap places. On the write side it shows up one cycle after the next write, when the load strobe fires early or not at all. A frozen count that is wrongly overwritten or released returns a later count at the first read after a second freeze. A lost status priority returns a count byte where the packed status byte was due. A control-port read that disturbs state is seen on the next data read of a channel with a pending freeze.

// File: rtl/tmr_bus_pkg.sv
package tmr_bus_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 16;

  // access scheme; value 0 on the control port means "freeze count"
  typedef enum logic [1:0] {
    ACC_FREEZE = 2'd0,
    ACC_LO     = 2'd1,
    ACC_HI     = 2'd2,
    ACC_WORD   = 2'd3
  } acc_e;

  // frozen-count progress shares the access encoding
  typedef enum logic [1:0] {
    SNAP_NONE = 2'd0,
    SNAP_LO   = 2'd1,
    SNAP_HI   = 2'd2,
    SNAP_WORD = 2'd3
  } snap_e;

  function automatic logic [BYTE_W-1:0] pack_status(
    input logic out_lvl, input acc_e acc, input logic [2:0] mode, input logic bcd);
    return {out_lvl, 1'b0, acc, mode, bcd};
  endfunction

  function automatic logic [CNT_W-1:0] form_load(
    input acc_e acc, input logic [BYTE_W-1:0] held, input logic [BYTE_W-1:0] din);
    case (acc)
      ACC_LO:  return {8'h00, din};
      ACC_HI:  return {din, 8'h00};
      default: return {din, held};
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(
    input logic [CNT_W-1:0] val, input logic upper);
    return upper ? val[CNT_W-1:BYTE_W] : val[BYTE_W-1:0];
  endfunction

endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode #(
  parameter int NUM_CH = 3,
  parameter int AW     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:1]        ctl_bits,
  output logic [NUM_CH-1:0] cfg_we,
  output logic [NUM_CH-1:0] freeze_req,
  output logic [NUM_CH-1:0] status_req,
  output logic [NUM_CH-1:0] data_we,
  output logic [NUM_CH-1:0] data_re
);

  localparam logic [AW-1:0] CTRL_ADDR = AW'(NUM_CH);

  logic ctl_write;
  logic is_readback;
  assign ctl_write   = bus_wr && (bus_addr == CTRL_ADDR);
  assign is_readback = (ctl_bits[7:6] == 2'b11);

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      cfg_we[i]     = 1'b0;
      freeze_req[i] = 1'b0;
      status_req[i] = 1'b0;
      data_we[i]    = bus_wr && (bus_addr == AW'(i));
      data_re[i]    = bus_rd && (bus_addr == AW'(i));
      if (ctl_write) begin
        if (is_readback) begin
          if (i < 3 && ctl_bits[i+1]) begin
            freeze_req[i] = !ctl_bits[5];
            status_req[i] = !ctl_bits[4];
          end
        end else if (ctl_bits[7:6] == 2'(i)) begin
          if (ctl_bits[5:4] == 2'b00) freeze_req[i] = 1'b1;
          else                        cfg_we[i]     = 1'b1;
        end
      end
    end
  end

  AST_ONE_DATA_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(data_we) && $onehot0(data_re)); // R3

  AST_CTRL_NOT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_write |-> (data_we == '0)); // R11

endmodule

// File: rtl/tmr_bus_chan.sv
module tmr_bus_chan
  import tmr_bus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_acc,
  input  logic [2:0]        cfg_mode,
  input  logic              cfg_bcd,
  input  logic              freeze_req,
  input  logic              status_req,
  input  logic              data_we,
  input  logic              data_re,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live_count,
  input  logic              live_out,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              load_stb,
  output logic [CNT_W-1:0]  load_val,
  output logic [2:0]        mode,
  output logic              bcd
);

  acc_e              acc_q;
  logic [2:0]        mode_q;
  logic              bcd_q;
  logic              wr_hi_q, rd_hi_q;
  logic [BYTE_W-1:0] held_q;
  snap_e             snap_q;
  logic [CNT_W-1:0]  snap_val_q;
  logic              stat_q;
  logic [BYTE_W-1:0] stat_val_q;
  logic              load_q;
  logic [CNT_W-1:0]  load_val_q;

  // named internal events
  logic snap_take, stat_take, word_hold, read_stat, read_snap, read_live;
  assign snap_take = freeze_req && (snap_q == SNAP_NONE);
  assign stat_take = status_req && !stat_q;
  assign word_hold = data_we && (acc_q == ACC_WORD) && !wr_hi_q;
  assign read_stat = data_re && stat_q;
  assign read_snap = data_re && !stat_q && (snap_q != SNAP_NONE);
  assign read_live = data_re && !stat_q && (snap_q == SNAP_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q      <= ACC_WORD;
      mode_q     <= 3'd0;
      bcd_q      <= 1'b0;
      wr_hi_q    <= 1'b0;
      rd_hi_q    <= 1'b0;
      held_q     <= '0;
      snap_q     <= SNAP_NONE;
      snap_val_q <= '0;
      stat_q     <= 1'b0;
      stat_val_q <= '0;
      load_q     <= 1'b0;
      load_val_q <= '0;
    end else begin
      load_q <= 1'b0;
      if (cfg_we) begin
        acc_q   <= acc_e'(cfg_acc);
        mode_q  <= cfg_mode;
        bcd_q   <= cfg_bcd;
        wr_hi_q <= 1'b0;
        rd_hi_q <= 1'b0;
      end
      if (word_hold) begin
        held_q  <= wdata;
        wr_hi_q <= 1'b1;
      end else if (data_we) begin
        load_q     <= 1'b1;
        load_val_q <= form_load(acc_q, held_q, wdata);
        wr_hi_q    <= 1'b0;
      end
      if (read_stat) stat_q <= 1'b0;
      if (read_snap) snap_q <= (snap_q == SNAP_WORD) ? SNAP_HI : SNAP_NONE;
      if (read_live && acc_q == ACC_WORD) rd_hi_q <= !rd_hi_q;
      if (snap_take) begin
        snap_q     <= snap_e'(acc_q);
        snap_val_q <= live_count;
      end
      if (stat_take) begin
        stat_q     <= 1'b1;
        stat_val_q <= pack_status(live_out, acc_q, mode_q, bcd_q);
      end
    end
  end

  always_comb begin
    if (stat_q)                   rd_byte = stat_val_q;
    else if (snap_q == SNAP_HI)   rd_byte = pick_byte(snap_val_q, 1'b1);
    else if (snap_q != SNAP_NONE) rd_byte = pick_byte(snap_val_q, 1'b0);
    else begin
      case (acc_q)
        ACC_LO:  rd_byte = pick_byte(live_count, 1'b0);
        ACC_HI:  rd_byte = pick_byte(live_count, 1'b1);
        default: rd_byte = pick_byte(live_count, rd_hi_q);
      endcase
    end
  end

  assign load_stb = load_q;
  assign load_val = load_val_q;
  assign mode     = mode_q;
  assign bcd      = bcd_q;

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_q != SNAP_NONE) && freeze_req |=> snap_val_q == $past(snap_val_q)); // R5

  AST_STAT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    read_stat |=> !stat_q); // R10

  AST_STAT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    read_stat && !freeze_req |=> snap_q == $past(snap_q)); // R10

  AST_WORD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    load_q && (acc_q == ACC_WORD) |-> $past(wr_hi_q) && !wr_hi_q); // R4

  AST_PTR_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !wr_hi_q && !rd_hi_q); // R2

  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |=> !load_q); // R3

endmodule

// File: rtl/tmr_bus_top.sv
module tmr_bus_top
  import tmr_bus_pkg::*;
#(
  parameter int NUM_CH = 3,
  localparam int AW    = $clog2(NUM_CH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           bus_addr,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [BYTE_W-1:0]       bus_wdata,
  output logic [BYTE_W-1:0]       bus_rdata,
  output logic [NUM_CH-1:0]       ch_load,
  output logic [NUM_CH*CNT_W-1:0] ch_load_val,
  output logic [NUM_CH*3-1:0]     ch_mode,
  output logic [NUM_CH-1:0]       ch_bcd,
  input  logic [NUM_CH*CNT_W-1:0] ch_count,
  input  logic [NUM_CH-1:0]       ch_out
);

  logic [NUM_CH-1:0] cfg_we, freeze_req, status_req, data_we, data_re;
  logic [BYTE_W-1:0] rd_bytes [NUM_CH];

  tmr_bus_decode #(.NUM_CH(NUM_CH), .AW(AW)) u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .ctl_bits   (bus_wdata[7:1]),
    .cfg_we     (cfg_we),
    .freeze_req (freeze_req),
    .status_req (status_req),
    .data_we    (data_we),
    .data_re    (data_re)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    tmr_bus_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we[g]),
      .cfg_acc    (bus_wdata[5:4]),
      .cfg_mode   (bus_wdata[3:1]),
      .cfg_bcd    (bus_wdata[0]),
      .freeze_req (freeze_req[g]),
      .status_req (status_req[g]),
      .data_we    (data_we[g]),
      .data_re    (data_re[g]),
      .wdata      (bus_wdata),
      .live_count (ch_count[g*CNT_W +: CNT_W]),
      .live_out   (ch_out[g]),
      .rd_byte    (rd_bytes[g]),
      .load_stb   (ch_load[g]),
      .load_val   (ch_load_val[g*CNT_W +: CNT_W]),
      .mode       (ch_mode[g*3 +: 3]),
      .bcd        (ch_bcd[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (bus_addr == AW'(i)) bus_rdata = rd_bytes[i];
  end

endmodule

// File: tb/sim_tmr_bus_top.sv
module sim_tmr_bus_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [2:0]  ch_load;
  logic [47:0] ch_load_val;
  logic [8:0]  ch_mode;
  logic [2:0]  ch_bcd;
  logic [15:0] cnt0 = 16'h1234, cnt1 = 16'hABCD, cnt2 = 16'h5A0F;
  logic [2:0]  ch_out = 3'b101;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tmr_bus_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_load(ch_load),
    .ch_load_val(ch_load_val), .ch_mode(ch_mode), .ch_bcd(ch_bcd),
    .ch_count({cnt2, cnt1, cnt0}), .ch_out(ch_out)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] r);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #2 r = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] r;
    bus_read(a, r);
    chk(req, {8'h00, r}, {8'h00, exp});
  endtask

  // kind: 0 write only, 1 read and compare, 2 write and expect load, 3 write and expect no load
  localparam int NV = 18;
  localparam logic [27:0] VEC [NV] = '{
    {2'd0, 2'd3, 8'h14, 16'h0000},  // R2 ch0 low-only, mode 2
    {2'd2, 2'd0, 8'h7E, 16'h007E},  // R3
    {2'd1, 2'd0, 8'h00, 16'h0034},  // R7
    {2'd1, 2'd0, 8'h00, 16'h0034},  // R7
    {2'd0, 2'd3, 8'h67, 16'h0000},  // R2 ch1 high-only, mode 3, decimal
    {2'd2, 2'd1, 8'h9C, 16'h9C00},  // R3
    {2'd1, 2'd1, 8'h00, 16'h00AB},  // R7
    {2'd1, 2'd1, 8'h00, 16'h00AB},  // R7
    {2'd0, 2'd3, 8'hB8, 16'h0000},  // R2 ch2 word, mode 4
    {2'd3, 2'd2, 8'h11, 16'h0000},  // R4 first byte held
    {2'd2, 2'd2, 8'h22, 16'h2211},  // R4
    {2'd1, 2'd2, 8'h00, 16'h000F},  // R7
    {2'd1, 2'd2, 8'h00, 16'h005A},  // R7
    {2'd1, 2'd2, 8'h00, 16'h000F},  // R7
    {2'd1, 2'd3, 8'h00, 16'h0000},  // R11
    {2'd0, 2'd3, 8'hE4, 16'h0000},  // R8 status of ch1
    {2'd1, 2'd1, 8'h00, 16'h0027},  // R9
    {2'd1, 2'd1, 8'h00, 16'h00AB}   // R10 released
  };

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 load", {13'd0, ch_load}, 16'h0000);
    chk("R1 mode", {7'd0, ch_mode}, 16'h0000);
    chk("R1 bcd", {13'd0, ch_bcd}, 16'h0000);
    rd_chk("R1 low first", 2'd0, 8'h34);

    for (int v = 0; v < NV; v++) begin
      logic [1:0] k, a;
      logic [7:0] d;
      logic [15:0] e;
      {k, a, d, e} = VEC[v];
      case (k)
        2'd0: bus_write(a, d);
        2'd1: rd_chk($sformatf("R7/R9/R10/R11 vec %0d", v), a, e[7:0]);
        2'd2: begin
          bus_write(a, d);
          chk($sformatf("R3/R4 strobe vec %0d", v), {13'd0, ch_load}, 16'(3'b001 << a));
          chk($sformatf("R3/R4 value vec %0d", v), ch_load_val[a*16 +: 16], e);
        end
        default: begin
          bus_write(a, d);
          chk($sformatf("R4 no load vec %0d", v), {13'd0, ch_load}, 16'h0000);
        end
      endcase
    end
    // R2 outputs
    chk("R2 modes", {7'd0, ch_mode}, {7'd0, 3'd4, 3'd3, 3'd2});
    chk("R2 bcd", {13'd0, ch_bcd}, 16'h0002);

    // R4 control byte resets write pointer
    bus_write(2'd3, 8'hB8);
    bus_write(2'd2, 8'h55);
    bus_write(2'd3, 8'hB8);
    bus_write(2'd2, 8'h66);
    chk("R4 held again", {13'd0, ch_load}, 16'h0000);
    bus_write(2'd2, 8'h77);
    chk("R4 pair", ch_load_val[47:32], 16'h7766);

    // R5 repeat freeze ignored, R6 word readout
    cnt2 = 16'h1A2B;
    bus_write(2'd3, 8'h80);
    cnt2 = 16'h3C4D;
    bus_write(2'd3, 8'h80);
    cnt2 = 16'h5E6F;
    rd_chk("R5 R6 frozen low", 2'd2, 8'h2B);
    rd_chk("R5 R6 frozen high", 2'd2, 8'h1A);
    rd_chk("R6 live low", 2'd2, 8'h6F);
    rd_chk("R6 live high", 2'd2, 8'h5E);

    // R10 status before count, R9 packing
    cnt0 = 16'h0102;
    bus_write(2'd3, 8'hC2);
    cnt0 = 16'h0304;
    rd_chk("R10 status first", 2'd0, 8'h94);
    rd_chk("R10 count next", 2'd0, 8'h02);
    rd_chk("R6 live after", 2'd0, 8'h04);

    // R8 repeated status freeze ignored
    bus_write(2'd3, 8'hE2);
    ch_out = 3'b100;
    bus_write(2'd3, 8'hE2);
    rd_chk("R8 status kept", 2'd0, 8'h94);
    rd_chk("R8 live after status", 2'd0, 8'h04);

    // R8 multi-channel count freeze, R11 quiet control read
    cnt0 = 16'h0A0B; cnt1 = 16'h0C0D; cnt2 = 16'h0E0F;
    bus_write(2'd3, 8'hDE);
    cnt0 = 16'hFFFF; cnt1 = 16'hFFFF; cnt2 = 16'hFFFF;
    rd_chk("R8 ch1 frozen", 2'd1, 8'h0C);
    rd_chk("R8 ch0 frozen", 2'd0, 8'h0B);
    rd_chk("R11 ctrl zero", 2'd3, 8'h00);
    rd_chk("R11 ch2 frozen low", 2'd2, 8'h0F);
    rd_chk("R8 ch2 frozen high", 2'd2, 8'h0E);
    rd_chk("R6 ch1 live", 2'd1, 8'hFF);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule